// File: doc/BRIEF.md
# Ethernet Stream Throughput Monitor

This block sits beside the 64-bit transmit and receive streams that join a packet source or sink to a 10G Ethernet MAC and watches them without taking part. Every stream signal, the ready included, is an input, so the monitor can never stall either path. For each direction it adds up the payload bytes and the number of frames that pass during a fixed window of clock cycles. At the end of each window it copies those sums into result registers that are only read.

Bytes on a beat come from the population count of the keep field. At the end of each frame a fixed 14-byte header is taken off the frame's byte total, so only the payload is counted. Each result register gives up its two low bits to a rolling period tag that steps on every window. Software that reads the same tag twice knows it has read a stale sample. A sticky flag per direction records any beat whose keep pattern breaks the stream rules.

Top module: `eth_rate_monitor`

## Requirements
- R1: A beat is counted only on a cycle where its valid and ready inputs are both high. On any other cycle the byte and frame sums of that direction do not change.
- R2: A counted beat adds the number of set bits of its 8-bit keep field to the running frame total. Keep bit 0 stands for the least significant data byte and bit 7 for the most significant.
- R3: A counted beat with the end-of-frame input high adds exactly one to the frame count of its direction.
- R4: On the end-of-frame beat, 14 is subtracted from the frame's byte total, which includes that beat, and the result is added to the window byte sum. A total below 14 adds zero. The frame total then restarts at zero, and it is not cleared at window boundaries.
- R5: The window ends on every WINDOW_CYCLES-th clock cycle after reset. On the clock edge that closes a window, all four result registers load. At every other edge they keep their value.
- R6: Each result register reads {sum[31:2], tag}, with the tag in bits 1:0. The tag is 01 after the first window and then steps 10, 11, 00, 01 and onward once per window.
- R7: The byte and frame sums are 32 bits wide and wrap. On the cycle that closes a window, they restart with only what that cycle's beat adds, so a beat on that cycle belongs to the next window.
- R8: A direction's error flag sets on a counted beat whose keep is not 0xFF while the end-of-frame input is low, or whose keep is not one of 0x01, 0x03, 0x07, 0x0F, 0x1F, 0x3F, 0x7F or 0xFF while it is high. The beat is still counted as its keep gives. The flag stays set until reset.
- R9: Synchronous active-high reset clears the sums, the frame totals, the tag, the window timer, the result registers and the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_keep | input | 8 | Transmit byte-enable mask |
| tx_last | input | 1 | Transmit end-of-frame marker |
| tx_valid | input | 1 | Transmit source has data |
| tx_ready | input | 1 | MAC accepts transmit data |
| rx_keep | input | 8 | Receive byte-enable mask |
| rx_last | input | 1 | Receive end-of-frame marker |
| rx_valid | input | 1 | MAC presents receive data |
| rx_ready | input | 1 | Sink accepts receive data |
| tx_byte_rate | output | 32 | Tagged transmit payload bytes of the last window |
| tx_frame_rate | output | 32 | Tagged transmit frame count of the last window |
| rx_byte_rate | output | 32 | Tagged receive payload bytes of the last window |
| rx_frame_rate | output | 32 | Tagged receive frame count of the last window |
| tx_keep_err | output | 1 | Sticky transmit keep-rule violation |
| rx_keep_err | output | 1 | Sticky receive keep-rule violation |

## Verification
The hardest case to reach is a counted beat on the very cycle that closes a window. It has to go to the new window while the old sum loads, and a frame that is still open has to carry its partial byte total across the boundary. The bench uses a short window and keeps both streams busy on almost every cycle. It sweeps every legal end-of-frame mask against zero to three full beats ahead of it, so that frame ends land on closing cycles again and again. Phases with pseudo-random valid and ready, with ready held low and with valid held low cover the cases where a beat is not counted.

// File: rtl/rate_mon_pkg.sv
package rate_mon_pkg;

    localparam int KEEP_W    = 8;
    localparam int SUM_W     = 32;
    localparam int TAG_W     = 2;
    localparam int HDR_BYTES = 14;
    localparam int LANES     = 2;
    localparam int BCNT_W    = $clog2(KEEP_W + 1);

    typedef struct packed {
        logic [KEEP_W-1:0] keep;
        logic              last;
        logic              valid;
        logic              ready;
    } tap_t;

    typedef struct packed {
        logic [SUM_W-1:0] bytes;
        logic [SUM_W-1:0] frames;
    } tally_t;

    function automatic logic [BCNT_W-1:0] keep_popcount(input logic [KEEP_W-1:0] k);
        logic [BCNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < KEEP_W; i++) begin
            n = n + BCNT_W'(k[i]);
        end
        return n;
    endfunction

    function automatic logic keep_legal(input logic [KEEP_W-1:0] k, input logic last);
        logic [KEEP_W-1:0] k_inc;
        k_inc = k + KEEP_W'(1);
        if (last) begin
            return (k != '0) && ((k & k_inc) == '0);
        end
        return k == {KEEP_W{1'b1}};
    endfunction

    function automatic logic [SUM_W-1:0] strip_header(input logic [SUM_W-1:0] total);
        if (total > SUM_W'(HDR_BYTES)) begin
            return total - SUM_W'(HDR_BYTES);
        end
        return '0;
    endfunction

endpackage

// File: rtl/window_timer.sv
module window_timer #(
    parameter int unsigned CYCLES = 32'h9502F90
) (
    input  logic                           clk,
    input  logic                           rst,
    output logic                           expire,
    output logic [rate_mon_pkg::TAG_W-1:0] next_tag
);
    import rate_mon_pkg::*;

    localparam int TW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

    logic [TW-1:0]    cnt_q;
    logic [TAG_W-1:0] tag_q;

    assign expire   = (cnt_q == TW'(CYCLES - 1));
    assign next_tag = tag_q + TAG_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tag_q <= '0;
        end else begin
            cnt_q <= expire ? '0 : cnt_q + TW'(1);
            if (expire) begin
                tag_q <= next_tag;
            end
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < CYCLES); // R5
    AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt_q == '0)); // R5
    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !expire |=> $stable(tag_q)); // R6

endmodule

// File: rtl/lane_counter.sv
module lane_counter (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 expire,
    input  rate_mon_pkg::tap_t   tap,
    output rate_mon_pkg::tally_t tally,
    output logic                 keep_err
);
    import rate_mon_pkg::*;

    logic             fire;
    logic             eof;
    logic [SUM_W-1:0] frame_q;
    logic [SUM_W-1:0] frame_sum;
    logic [SUM_W-1:0] byte_add;
    logic [SUM_W-1:0] frame_add;
    tally_t           acc_q;
    logic             err_q;

    assign fire      = tap.valid & tap.ready;
    assign eof       = fire & tap.last;
    assign frame_sum = frame_q + SUM_W'(keep_popcount(tap.keep));
    assign byte_add  = eof ? strip_header(frame_sum) : '0;
    assign frame_add = SUM_W'(eof);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            acc_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (fire) begin
                frame_q <= tap.last ? '0 : frame_sum;
            end
            if (expire) begin
                acc_q.bytes  <= byte_add;
                acc_q.frames <= frame_add;
            end else begin
                acc_q.bytes  <= acc_q.bytes + byte_add;
                acc_q.frames <= acc_q.frames + frame_add;
            end
            if (fire && !keep_legal(tap.keep, tap.last)) begin
                err_q <= 1'b1;
            end
        end
    end

    assign tally    = acc_q;
    assign keep_err = err_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(tap.valid && tap.ready) && !expire) |=> ($stable(acc_q) && $stable(frame_q))); // R1
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (tap.valid && tap.ready && tap.last && !expire) |=> (acc_q.frames == $past(acc_q.frames) + 32'd1)); // R3
    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
        (tap.valid && tap.ready && tap.last) |=> (frame_q == '0)); // R4
    AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (expire && !(tap.valid && tap.ready)) |=> (acc_q.bytes == '0 && acc_q.frames == '0)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R8

endmodule

// File: rtl/tagged_result.sv
module tagged_result (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           expire,
    input  logic [rate_mon_pkg::TAG_W-1:0] next_tag,
    input  rate_mon_pkg::tally_t           tally,
    output logic [rate_mon_pkg::SUM_W-1:0] byte_reg,
    output logic [rate_mon_pkg::SUM_W-1:0] frame_reg
);
    import rate_mon_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_reg  <= '0;
            frame_reg <= '0;
        end else if (expire) begin
            byte_reg  <= {tally.bytes[SUM_W-1:TAG_W], next_tag};
            frame_reg <= {tally.frames[SUM_W-1:TAG_W], next_tag};
        end
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !expire |=> ($stable(byte_reg) && $stable(frame_reg))); // R5
    AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
        expire |=> (byte_reg[TAG_W-1:0] == $past(byte_reg[TAG_W-1:0]) + TAG_W'(1))); // R6
    AST_TAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        byte_reg[TAG_W-1:0] == frame_reg[TAG_W-1:0]); // R6

endmodule

// File: rtl/eth_rate_monitor.sv
module eth_rate_monitor #(
    parameter int unsigned WINDOW_CYCLES = 32'h9502F90
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  tx_keep,
    input  logic        tx_last,
    input  logic        tx_valid,
    input  logic        tx_ready,
    input  logic [7:0]  rx_keep,
    input  logic        rx_last,
    input  logic        rx_valid,
    input  logic        rx_ready,
    output logic [31:0] tx_byte_rate,
    output logic [31:0] tx_frame_rate,
    output logic [31:0] rx_byte_rate,
    output logic [31:0] rx_frame_rate,
    output logic        tx_keep_err,
    output logic        rx_keep_err
);
    import rate_mon_pkg::*;

    logic             expire;
    logic [TAG_W-1:0] next_tag;
    tap_t             taps     [LANES];
    tally_t           tallies  [LANES];
    logic [SUM_W-1:0] byte_regs[LANES];
    logic [SUM_W-1:0] frm_regs [LANES];
    logic             errs     [LANES];

    assign taps[0] = '{keep: tx_keep, last: tx_last, valid: tx_valid, ready: tx_ready};
    assign taps[1] = '{keep: rx_keep, last: rx_last, valid: rx_valid, ready: rx_ready};

    window_timer #(.CYCLES(WINDOW_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .next_tag (next_tag)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_counter u_count (
            .clk      (clk),
            .rst      (rst),
            .expire   (expire),
            .tap      (taps[g]),
            .tally    (tallies[g]),
            .keep_err (errs[g])
        );
        tagged_result u_result (
            .clk       (clk),
            .rst       (rst),
            .expire    (expire),
            .next_tag  (next_tag),
            .tally     (tallies[g]),
            .byte_reg  (byte_regs[g]),
            .frame_reg (frm_regs[g])
        );
    end

    assign tx_byte_rate  = byte_regs[0];
    assign tx_frame_rate = frm_regs[0];
    assign rx_byte_rate  = byte_regs[1];
    assign rx_frame_rate = frm_regs[1];
    assign tx_keep_err   = errs[0];
    assign rx_keep_err   = errs[1];

endmodule

// File: tb/eth_rate_monitor_bench.sv
module eth_rate_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 24;
    localparam int PHASE_LEN  = 120;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  keep_in [2];
    logic        last_in [2];
    logic        valid_in[2];
    logic        ready_in[2];
    logic [31:0] tx_byte_rate, tx_frame_rate, rx_byte_rate, rx_frame_rate;
    logic        tx_keep_err, rx_keep_err;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_rate_monitor #(.WINDOW_CYCLES(WIN)) u_eth_rate_monitor (
        .clk           (clk),
        .rst           (rst),
        .tx_keep       (keep_in[0]),
        .tx_last       (last_in[0]),
        .tx_valid      (valid_in[0]),
        .tx_ready      (ready_in[0]),
        .rx_keep       (keep_in[1]),
        .rx_last       (last_in[1]),
        .rx_valid      (valid_in[1]),
        .rx_ready      (ready_in[1]),
        .tx_byte_rate  (tx_byte_rate),
        .tx_frame_rate (tx_frame_rate),
        .rx_byte_rate  (rx_byte_rate),
        .rx_frame_rate (rx_frame_rate),
        .tx_keep_err   (tx_keep_err),
        .rx_keep_err   (rx_keep_err)
    );

    // reference model state
    logic [31:0] acc_b[2], acc_f[2], frame_b[2], exp_b[2], exp_f[2];
    logic [1:0]  tag;
    logic        exp_err[2];
    int          cyc;
    int          body_left[2], fidx[2];
    logic [7:0]  fmask[2];
    bit          inject[2];
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, tx_byte_rate,  exp_b[0]);
        check(req, tx_frame_rate, exp_f[0]);
        check(req, rx_byte_rate,  exp_b[1]);
        check(req, rx_frame_rate, exp_f[1]);
        check(req, 32'(tx_keep_err), 32'(exp_err[0]));
        check(req, 32'(rx_keep_err), 32'(exp_err[1]));
    endtask

    function automatic int ones(input logic [7:0] k);
        int n = 0;
        for (int i = 0; i < 8; i++) if (k[i]) n++;
        return n;
    endfunction

    function automatic logic [7:0] mask_of(input int idx);
        return 8'((9'd1 << ((idx % 8) + 1)) - 9'd1);
    endfunction

    task automatic model_reset();
        for (int l = 0; l < 2; l++) begin
            acc_b[l] = '0; acc_f[l] = '0; frame_b[l] = '0;
            exp_b[l] = '0; exp_f[l] = '0; exp_err[l] = 1'b0;
            keep_in[l] = 8'hFF; last_in[l] = 1'b0; valid_in[l] = 1'b0; ready_in[l] = 1'b0;
            body_left[l] = 0; fidx[l] = 0; fmask[l] = mask_of(0); inject[l] = 1'b0;
        end
        tag = '0;
        cyc = 0;
    endtask

    // mode 0: always, 1: pseudo-random, 2: ready low, 3: valid low
    task automatic run_cycle(input int mode);
        bit closing;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        closing = ((cyc % WIN) == WIN - 1);
        for (int l = 0; l < 2; l++) begin
            logic v, r, f;
            logic [31:0] add_b, add_f;
            case (mode)
                0: begin v = 1'b1; r = 1'b1; end
                1: begin v = lfsr[2*l] | lfsr[5]; r = lfsr[2*l+1] | lfsr[9]; end
                2: begin v = 1'b1; r = 1'b0; end
                default: begin v = 1'b0; r = 1'b1; end
            endcase
            last_in[l]  = (body_left[l] == 0);
            keep_in[l]  = last_in[l] ? fmask[l] : 8'hFF;
            if (inject[l]) begin
                if (l == 0) keep_in[l] = last_in[l] ? 8'h05 : 8'h7F;
                else        keep_in[l] = last_in[l] ? 8'h00 : 8'h0F;
            end
            valid_in[l] = v;
            ready_in[l] = r;
            f = v & r;
            add_b = '0;
            add_f = '0;
            if (f) begin
                int sum = int'(frame_b[l]) + ones(keep_in[l]);
                if (inject[l]) begin
                    exp_err[l] = 1'b1; // R8
                    inject[l]  = 1'b0;
                end
                if (last_in[l]) begin
                    add_b = (sum >= 14) ? 32'(sum - 14) : 32'd0; // R4 saturation
                    add_f = 32'd1;
                    frame_b[l] = '0;
                    fidx[l]++;
                    body_left[l] = (fidx[l] / 8) % 4;
                    fmask[l] = mask_of(fidx[l]);
                end else begin
                    frame_b[l] = 32'(sum);
                    body_left[l]--;
                end
            end
            if (closing) begin
                exp_b[l] = {acc_b[l][31:2], tag + 2'd1};
                exp_f[l] = {acc_f[l][31:2], tag + 2'd1};
                acc_b[l] = add_b;
                acc_f[l] = add_f;
            end else begin
                acc_b[l] = acc_b[l] + add_b;
                acc_f[l] = acc_f[l] + add_f;
            end
        end
        if (closing) tag = tag + 2'd1;
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic run_phase(input int mode, input string req);
        for (int i = 0; i < PHASE_LEN; i++) begin
            run_cycle(mode);
            check_all(req);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R9 reset state");
        rst = 1'b0;
        run_phase(0, "R2 R4 R5 R6 R7 full rate");
        run_phase(1, "R1 R3 random handshake");
        run_phase(2, "R1 ready low");
        run_phase(1, "R3 R4 random handshake");
        run_phase(3, "R1 valid low");
        inject[0] = 1'b1;
        inject[1] = 1'b1;
        run_phase(0, "R8 keep rule error");
        run_phase(1, "R8 error sticky");
        for (int i = 0; i < 10 * WIN; i++) begin
            run_cycle(0);
            check_all("R5 R6 R7 long run");
        end
        rst = 1'b1;
        run_cycle(0);
        model_reset();
        check_all("R9 reset mid traffic");
        rst = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule